// File: doc/BRIEF.md
# Microcoded Next-State Sequencer

This block is the control engine of a multicycle 32-bit processor. A six-bit micro-program counter selects one word of a writable control store. That word drives the datapath strobes directly, and it also decides where the sequencer goes next. The next state can come from a literal field inside the word. It can come from an opcode-indexed dispatch table, which is how the end of instruction fetch branches to an execute routine. It can also come from a two-entry table indexed by the comparison result from the datapath, which is how conditional branches fork.

All three tables are register arrays with combinational reads. They are filled through a simple write port before the processor runs, so the same hardware can run any microprogram. Reset is synchronous and places the sequencer at microstate 0, the first fetch state. Two bits of the control word select the next-state source. They must never both be set. If they are, the sequencer freezes in its current state and flags the fault for as long as that word is current.

Top module: `ucode_sequencer`

## Requirements
- R1: When `rst` is high at a rising edge, `upc` becomes 0. The state does not change between edges, so reset takes effect only at the edge.
- R2: The outputs always reflect the control-store word at address `upc`, with this layout:
  - bits [5:0]: next-state literal
  - bit 6: `en_rf_out`; bit 7: `en_mem_out`; bit 8: `en_alu_out`; bit 9: `en_alu2_out`; bit 10: `en_pc_out`; bit 11: `en_imm_out`
  - bit 12: `ld_pc`; bit 13: `ld_ir`; bit 14: `ld_addr`; bit 15: `ld_opa`; bit 16: `ld_opb`; bit 17: `ld_flag`
  - bit 18: `rf_we`; bit 19: `mem_we`
  - bits [21:20]: `rf_port_sel`; bits [23:22]: `alu_op` (00 add, 01 subtract, 10 nand, 11 increment A)
  - bit 24: `dispatch`; bit 25: `cond_branch`
- R3: When bits 25:24 of the current word are 00, the next `upc` is that word's bits [5:0].
- R4: When bits 25:24 are 01, the next `upc` is the dispatch-table entry indexed by `opcode`.
- R5: When bits 25:24 are 10, the next `upc` is condition-table entry 1 if `cond` is high and entry 0 if it is low.
- R6: When bits 25:24 are 11, `upc` holds its value, and `seq_fault` is high for as long as that word is current.
- R7: A write happens at a rising edge while `prog_we` is high. The target is chosen by `prog_sel`:
  - 0: control store, address `prog_addr`, data all 26 bits of `prog_data`
  - 1: dispatch table, address `prog_addr[3:0]`, data `prog_data[5:0]`
  - 2: condition table, address `prog_addr[0]`, data `prog_data[5:0]`
  - 3: writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset to microstate 0 |
| opcode | input | 4 | Instruction opcode used for dispatch |
| cond | input | 1 | Comparison result from the datapath |
| prog_we | input | 1 | Table write strobe |
| prog_sel | input | 2 | Target table: 0 control store, 1 dispatch, 2 condition |
| prog_addr | input | 6 | Write address |
| prog_data | input | 26 | Write data |
| upc | output | 6 | Current microstate |
| en_rf_out | output | 1 | Register file drives the bus |
| en_mem_out | output | 1 | Memory drives the bus |
| en_alu_out | output | 1 | ALU drives the bus |
| en_alu2_out | output | 1 | Second ALU path drives the bus |
| en_pc_out | output | 1 | PC drives the bus |
| en_imm_out | output | 1 | Sign-extended offset drives the bus |
| ld_pc | output | 1 | Load PC |
| ld_ir | output | 1 | Load instruction register |
| ld_addr | output | 1 | Load memory address register |
| ld_opa | output | 1 | Load ALU operand A |
| ld_opb | output | 1 | Load ALU operand B |
| ld_flag | output | 1 | Load comparison flag |
| rf_we | output | 1 | Register file write enable |
| mem_we | output | 1 | Memory write enable |
| rf_port_sel | output | 2 | Register-number field select |
| alu_op | output | 2 | ALU function code |
| dispatch | output | 1 | Next state from dispatch table |
| cond_branch | output | 1 | Next state from condition table |
| seq_fault | output | 1 | Both next-state source bits set |

## Verification
A wrong next-state choice appears on `upc` one edge after the bad word is current. From that edge on, every strobe output follows the wrong store word, so the error is visible at once rather than instructions later. The bench walks full micro-routines for several opcodes and both condition values, comparing `upc` and all twenty strobe bits at every step. A bad table write or a reset that lands in the wrong state therefore shows within one to three cycles.

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
  parameter int STATE_W = 6,
  parameter int OP_W    = 4,
  parameter int WORD_W  = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    opcode,
  input  logic               cond,
  input  logic               prog_we,
  input  logic [1:0]         prog_sel,
  input  logic [STATE_W-1:0] prog_addr,
  input  logic [WORD_W-1:0]  prog_data,
  output logic [STATE_W-1:0] upc,
  output logic               en_rf_out,
  output logic               en_mem_out,
  output logic               en_alu_out,
  output logic               en_alu2_out,
  output logic               en_pc_out,
  output logic               en_imm_out,
  output logic               ld_pc,
  output logic               ld_ir,
  output logic               ld_addr,
  output logic               ld_opa,
  output logic               ld_opb,
  output logic               ld_flag,
  output logic               rf_we,
  output logic               mem_we,
  output logic [1:0]         rf_port_sel,
  output logic [1:0]         alu_op,
  output logic               dispatch,
  output logic               cond_branch,
  output logic               seq_fault
);
  localparam int MAIN_N = 1 << STATE_W;
  localparam int SEQ_N  = 1 << OP_W;

  logic [WORD_W-1:0]  main_rom [MAIN_N];
  logic [STATE_W-1:0] seq_rom  [SEQ_N];
  logic [STATE_W-1:0] cond_rom [2];

  logic [WORD_W-1:0]  word;
  logic [1:0]         src;
  logic [STATE_W-1:0] seq_nx, cond_nx;

  assign word    = main_rom[upc];
  assign src     = word[25:24];
  assign seq_nx  = seq_rom[opcode];
  assign cond_nx = cond_rom[cond];

  always_ff @(posedge clk) begin
    if (prog_we) begin
      case (prog_sel)
        2'd0: main_rom[prog_addr] <= prog_data;
        2'd1: seq_rom[prog_addr[OP_W-1:0]] <= prog_data[STATE_W-1:0];
        2'd2: cond_rom[prog_addr[0]] <= prog_data[STATE_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= '0;
    else begin
      case (src)
        2'b00: upc <= word[STATE_W-1:0];
        2'b01: upc <= seq_nx;
        2'b10: upc <= cond_nx;
        default: upc <= upc;
      endcase
    end
  end

  assign en_rf_out   = word[6];
  assign en_mem_out  = word[7];
  assign en_alu_out  = word[8];
  assign en_alu2_out = word[9];
  assign en_pc_out   = word[10];
  assign en_imm_out  = word[11];
  assign ld_pc       = word[12];
  assign ld_ir       = word[13];
  assign ld_addr     = word[14];
  assign ld_opa      = word[15];
  assign ld_opb      = word[16];
  assign ld_flag     = word[17];
  assign rf_we       = word[18];
  assign mem_we      = word[19];
  assign rf_port_sel = word[21:20];
  assign alu_op      = word[23:22];
  assign dispatch    = word[24];
  assign cond_branch = word[25];
  assign seq_fault   = dispatch & cond_branch;

  p_reset_state_r1: assert property (@(posedge clk) rst |=> upc == '0);
  p_literal_next_r3: assert property (@(posedge clk) disable iff (rst)
    (!dispatch && !cond_branch) |=> upc == $past(word[STATE_W-1:0]));
  p_dispatch_next_r4: assert property (@(posedge clk) disable iff (rst)
    (dispatch && !cond_branch) |=> upc == $past(seq_nx));
  p_cond_next_r5: assert property (@(posedge clk) disable iff (rst)
    (cond_branch && !dispatch) |=> upc == $past(cond_nx));
  p_fault_hold_r6: assert property (@(posedge clk) disable iff (rst)
    seq_fault |=> $stable(upc));
endmodule

// File: tb/ucode_sequencer_test.sv
module ucode_sequencer_test;
  logic clk = 0;
  logic rst = 1;
  logic [3:0] opcode = 0;
  logic cond = 0;
  logic prog_we = 0;
  logic [1:0] prog_sel = 0;
  logic [5:0] prog_addr = 0;
  logic [25:0] prog_data = 0;
  logic [5:0] upc;
  logic en_rf_out, en_mem_out, en_alu_out, en_alu2_out, en_pc_out, en_imm_out;
  logic ld_pc, ld_ir, ld_addr, ld_opa, ld_opb, ld_flag, rf_we, mem_we;
  logic [1:0] rf_port_sel, alu_op;
  logic dispatch, cond_branch, seq_fault;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ucode_sequencer uut (
    .clk(clk), .rst(rst), .opcode(opcode), .cond(cond),
    .prog_we(prog_we), .prog_sel(prog_sel), .prog_addr(prog_addr), .prog_data(prog_data),
    .upc(upc), .en_rf_out(en_rf_out), .en_mem_out(en_mem_out), .en_alu_out(en_alu_out),
    .en_alu2_out(en_alu2_out), .en_pc_out(en_pc_out), .en_imm_out(en_imm_out),
    .ld_pc(ld_pc), .ld_ir(ld_ir), .ld_addr(ld_addr), .ld_opa(ld_opa), .ld_opb(ld_opb),
    .ld_flag(ld_flag), .rf_we(rf_we), .mem_we(mem_we), .rf_port_sel(rf_port_sel),
    .alu_op(alu_op), .dispatch(dispatch), .cond_branch(cond_branch), .seq_fault(seq_fault)
  );

  function automatic logic [25:0] mword(input int s);
    logic [25:0] w;
    w = '0;
    if (s == 0) w = (26'd1 << 10) | (26'd1 << 14) | 26'd1;
    else if (s == 1) w = (26'd1 << 24) | (26'd3 << 22) | (26'd1 << 12) | (26'd1 << 13);
    else if (s == 21) w = (26'd1 << 25) | (26'd1 << 17) | (26'd1 << 8);
    else if (s == 23) w = (26'd3 << 24) | (26'd1 << 19);
    else if (s >= 16 && s < 32)
      w = (26'(s & 3) << 20) | (26'((s >> 2) & 3) << 22) | (26'd1 << 18) | (26'(s & 1) << 6)
        | (26'((s >> 1) & 1) << 7) | (26'(s & 1) << 9) | (26'(s & 1) << 11) | (26'((s >> 1) & 1) << 15)
        | (26'((s >> 2) & 1) << 16);
    else if (s == 40) w = (26'd1 << 12) | (26'd1 << 11);
    return w;
  endfunction

  function automatic logic [19:0] strobes();
    return {cond_branch, dispatch, alu_op, rf_port_sel, mem_we, rf_we, ld_flag, ld_opb,
            ld_opa, ld_addr, ld_ir, ld_pc, en_imm_out, en_pc_out, en_alu2_out, en_alu_out,
            en_mem_out, en_rf_out};
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic prog(input logic [1:0] sel, input logic [5:0] a, input logic [25:0] d);
    prog_sel = sel; prog_addr = a; prog_data = d; prog_we = 1;
    step();
    prog_we = 0;
  endtask

  task automatic chk_state(input string req, input logic [5:0] exp);
    tests++;
    if (upc !== exp) begin
      fails++;
      $display("FAIL %s: upc actual %0d expected %0d", req, upc, exp);
    end
    tests++;
    if (strobes() !== mword(int'(exp))[25:6]) begin
      fails++;
      $display("FAIL R2: strobes at state %0d actual %h expected %h", exp, strobes(), mword(int'(exp))[25:6]);
    end
  endtask

  // {opcode, cond, dispatch target, state after}
  localparam logic [16:0] VEC [6] = '{
    {4'd0,  1'b0, 6'd16, 6'd0},
    {4'd3,  1'b1, 6'd19, 6'd0},
    {4'd5,  1'b1, 6'd21, 6'd40},
    {4'd5,  1'b0, 6'd21, 6'd0},
    {4'd10, 1'b0, 6'd26, 6'd0},
    {4'd15, 1'b1, 6'd31, 6'd0}
  };

  initial begin
    for (int s = 0; s < 64; s++) prog(2'd0, 6'(s), mword(s));
    for (int o = 0; o < 16; o++) prog(2'd1, 6'(o), 26'(16 + o));
    prog(2'd2, 6'd0, 26'd0);
    prog(2'd2, 6'd1, 26'd40);
    chk_state("R1", 6'd0);
    rst = 0;
    for (int i = 0; i < 6; i++) begin
      chk_state("R1", 6'd0);
      step();
      chk_state("R3", 6'd1);
      opcode = VEC[i][16:13];
      cond = VEC[i][12];
      step();
      chk_state("R4", VEC[i][11:6]);
      step();
      chk_state(VEC[i][11:6] == 6'd21 ? "R5" : "R3", VEC[i][5:0]);
      if (VEC[i][5:0] == 6'd40) begin
        step();
        chk_state("R3", 6'd0);
      end
    end
    // R6: illegal select holds state and raises fault
    opcode = 4'd7;
    step();
    step();
    chk_state("R4", 6'd23);
    tests++;
    if (seq_fault !== 1'b1) begin fails++; $display("FAIL R6: seq_fault actual %b expected 1", seq_fault); end
    step();
    chk_state("R6", 6'd23);
    step();
    chk_state("R6", 6'd23);
    // R1: reset acts only at an edge
    #3 rst = 1;
    #3;
    tests++;
    if (upc !== 6'd23) begin fails++; $display("FAIL R1: upc before edge actual %0d expected 23", upc); end
    step();
    chk_state("R1", 6'd0);
    tests++;
    if (seq_fault !== 1'b0) begin fails++; $display("FAIL R6: seq_fault actual %b expected 0", seq_fault); end
    // R7: select 3 writes nothing; dispatch table rewrite takes effect
    prog(2'd3, 6'd0, 26'h3ffffff);
    prog(2'd3, 6'd1, 26'h3ffffff);
    prog(2'd1, 6'd2, 26'd40);
    chk_state("R7", 6'd0);
    rst = 0;
    opcode = 4'd2;
    step();
    chk_state("R7", 6'd1);
    step();
    chk_state("R7", 6'd40);
    step();
    chk_state("R7", 6'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule